// File: doc/BRIEF.md
# Redundant Clock Failover Switch

This block takes two reference clocks of roughly 13 MHz and drives a single output clock from one of them. A static strap input, `pri_sel`, names the preferred (primary) input. The other input is the backup (secondary). While the primary toggles, it drives the output. The block watches the primary from the secondary's clock domain. When the primary goes quiet for a fixed number of secondary cycles, the output is handed to the secondary without producing a runt pulse.

When the primary comes back, it has to prove itself before it is taken back. It must run for a fixed qualification count of its own cycles. Only then is the output handed back, again cleanly. If the primary drops out during qualification, the count starts over. A status output tells the system which input is gated onto the output.

`pri_sel` is meant to be strapped. The select is decoded combinationally into primary and secondary clock nets, so `pri_sel` is changed only while `rst` is high.

Top module: `clk_failover`

## Requirements
- R1: With `pri_sel`=1, input A (`clk_a`) is primary and B is secondary. With `pri_sel`=0, input B is primary. After reset, with both inputs running, `clk_out` follows the primary input.
- R2: `active_is_a` is 1 exactly while input A is gated onto `clk_out`, and 0 while input B is gated on or while no input is gated on.
- R3: If the primary shows no edge for `LOSS_CYCLES` (default 8) secondary cycles, `clk_out` follows the secondary within 30 secondary cycles of the primary stopping.
- R4: The handover never produces a high or low phase on `clk_out` shorter than the shorter input half-period, and the two inputs are never gated on together.
- R5: A primary that resumes is not gated on again before `QUAL_CYCLES` (default 1024) of its own cycles have passed since it resumed. It drives `clk_out` again within `QUAL_CYCLES`+46 of its cycles after resuming.
- R6: If the primary stops again for at least `LOSS_CYCLES` secondary cycles during qualification, the qualification count restarts from zero when it next resumes.
- R7: `rst` is asynchronous and active high. While it is high, `clk_out` is held low and `active_is_a` is 0. When it is released, the primary is the requested source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Reference clock input A |
| clk_b | input | 1 | Reference clock input B |
| rst | input | 1 | Asynchronous active-high reset |
| pri_sel | input | 1 | Static primary choice: 1 selects A as primary, 0 selects B |
| clk_out | output | 1 | Gated output clock |
| active_is_a | output | 1 | High while input A drives `clk_out` |

## Verification
The bench compares `clk_out` against the expected input clock at half-nanosecond offsets, so no sample coincides with an input clock edge. It reads `active_is_a` at the same instants.

Each result has a known deadline, and the checks are timed to fall inside it:
- **Reset state:** checked while `rst` is still high.
- **Primary after reset:** checked 40 input cycles after release.
- **Loss switchover:** due about 13 secondary cycles after the primary stops, and checked at 30.
- **Holdoff:** checked at 1000 primary cycles after resumption, which is safely before the 1024-cycle release. The return is then checked at 1070 cycles.

A continuous monitor timestamps every `clk_out` edge and flags any phase shorter than 37 ns.

// File: rtl/cfo_pkg.sv
package cfo_pkg;
  localparam int unsigned LOSS_DEFAULT = 8;
  localparam int unsigned QUAL_DEFAULT = 1024;
  localparam int unsigned SYNC_DEFAULT = 2;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/cfo_sync.sv
module cfo_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cfo_qualifier.sv
module cfo_qualifier
  import cfo_pkg::*;
#(
  parameter int unsigned QUAL_CYCLES = QUAL_DEFAULT,
  parameter int unsigned SYNC_STAGES = SYNC_DEFAULT
) (
  input  logic pclk,
  input  logic rst,
  input  logic loss_tgl,
  output logic p_tgl,
  output logic good_tgl
);
  localparam int unsigned CW = cnt_width(QUAL_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(QUAL_CYCLES - 1);
  localparam logic [CW-1:0] DONE = CW'(QUAL_CYCLES);

  logic          loss_s, loss_d, loss_seen;
  logic          armed;
  logic [CW-1:0] cnt_q;

  // Activity beacon: flips on every primary rising edge
  always_ff @(posedge pclk or posedge rst) begin
    if (rst) p_tgl <= 1'b0;
    else     p_tgl <= ~p_tgl;
  end

  cfo_sync #(.STAGES(SYNC_STAGES)) u_loss_sync (
    .clk(pclk), .rst(rst), .d(loss_tgl), .q(loss_s)
  );

  always_ff @(posedge pclk or posedge rst) begin
    if (rst) loss_d <= 1'b0;
    else     loss_d <= loss_s;
  end

  assign loss_seen = loss_s ^ loss_d;

  // Qualification counter, restarted by every loss event
  always_ff @(posedge pclk or posedge rst) begin
    if (rst) begin
      cnt_q    <= '0;
      armed    <= 1'b0;
      good_tgl <= 1'b0;
    end else if (loss_seen) begin
      cnt_q <= '0;
      armed <= 1'b1;
    end else if (armed) begin
      if (cnt_q == LAST) begin
        cnt_q    <= DONE;
        armed    <= 1'b0;
        good_tgl <= ~good_tgl;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  p_cnt_bound_r5: assert property (@(posedge pclk) disable iff (rst)
    cnt_q <= DONE);

  p_good_after_full_r5: assert property (@(posedge pclk) disable iff (rst)
    !$stable(good_tgl) |-> $past(cnt_q) == LAST);

  p_restart_r6: assert property (@(posedge pclk) disable iff (rst)
    loss_seen |=> cnt_q == '0);
endmodule

// File: rtl/cfo_loss_det.sv
module cfo_loss_det
  import cfo_pkg::*;
#(
  parameter int unsigned LOSS_CYCLES = LOSS_DEFAULT,
  parameter int unsigned SYNC_STAGES = SYNC_DEFAULT
) (
  input  logic sclk,
  input  logic rst,
  input  logic p_tgl,
  input  logic good_tgl,
  output logic loss_tgl,
  output logic on_sec
);
  localparam int unsigned TW = cnt_width(LOSS_CYCLES);
  localparam logic [TW-1:0] TLAST = TW'(LOSS_CYCLES - 1);
  localparam logic [TW-1:0] TMAX  = TW'(LOSS_CYCLES);

  logic          ps, ps_d, p_edge;
  logic          gs, gs_d, g_evt;
  logic          fire;
  logic [TW-1:0] tmo_q;

  cfo_sync #(.STAGES(SYNC_STAGES)) u_act_sync (
    .clk(sclk), .rst(rst), .d(p_tgl), .q(ps)
  );
  cfo_sync #(.STAGES(SYNC_STAGES)) u_good_sync (
    .clk(sclk), .rst(rst), .d(good_tgl), .q(gs)
  );

  always_ff @(posedge sclk or posedge rst) begin
    if (rst) begin
      ps_d <= 1'b0;
      gs_d <= 1'b0;
    end else begin
      ps_d <= ps;
      gs_d <= gs;
    end
  end

  assign p_edge = ps ^ ps_d;
  assign g_evt  = gs ^ gs_d;
  assign fire   = !p_edge && (tmo_q == TLAST);

  // Silence timer: saturates so that one dropout fires once
  always_ff @(posedge sclk or posedge rst) begin
    if (rst)                 tmo_q <= '0;
    else if (p_edge)         tmo_q <= '0;
    else if (tmo_q != TMAX)  tmo_q <= tmo_q + 1'b1;
  end

  always_ff @(posedge sclk or posedge rst) begin
    if (rst) begin
      loss_tgl <= 1'b0;
      on_sec   <= 1'b0;
    end else if (fire) begin
      loss_tgl <= ~loss_tgl;
      on_sec   <= 1'b1;
    end else if (g_evt) begin
      on_sec <= 1'b0;
    end
  end

  p_tmo_bound_r3: assert property (@(posedge sclk) disable iff (rst)
    tmo_q <= TMAX);

  p_loss_sets_sec_r3: assert property (@(posedge sclk) disable iff (rst)
    fire |=> (on_sec && !$stable(loss_tgl)));
endmodule

// File: rtl/cfo_glitchless_mux.sv
module cfo_glitchless_mux
  import cfo_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_DEFAULT
) (
  input  logic pclk,
  input  logic sclk,
  input  logic rst,
  input  logic use_sec,
  output logic clk_out,
  output logic en_p,
  output logic en_s
);
  logic req_p_s, req_s_s;
  logic kill_p;

  // Enable request, synchronised into each clock domain
  cfo_sync #(.STAGES(SYNC_STAGES)) u_p_sync (
    .clk(pclk), .rst(rst), .d(~use_sec & ~en_s), .q(req_p_s)
  );
  cfo_sync #(.STAGES(SYNC_STAGES)) u_s_sync (
    .clk(sclk), .rst(rst), .d(use_sec & ~en_p), .q(req_s_s)
  );

  // A dead primary cannot clock its own enable low, so the loss flag clears it
  assign kill_p = rst | use_sec;

  always_ff @(negedge pclk or posedge kill_p) begin
    if (kill_p) en_p <= 1'b0;
    else        en_p <= req_p_s;
  end

  always_ff @(negedge sclk or posedge rst) begin
    if (rst) en_s <= 1'b0;
    else     en_s <= req_s_s;
  end

  assign clk_out = (pclk & en_p) | (sclk & en_s);

  p_excl_r4: assert property (@(posedge sclk) disable iff (rst)
    !(en_p && en_s));

  p_kill_r3: assert property (@(posedge sclk) disable iff (rst)
    use_sec |-> !en_p);
endmodule

// File: rtl/clk_failover.sv
module clk_failover
  import cfo_pkg::*;
#(
  parameter int unsigned LOSS_CYCLES = LOSS_DEFAULT,
  parameter int unsigned QUAL_CYCLES = QUAL_DEFAULT,
  parameter int unsigned SYNC_STAGES = SYNC_DEFAULT
) (
  input  logic clk_a,
  input  logic clk_b,
  input  logic rst,
  input  logic pri_sel,
  output logic clk_out,
  output logic active_is_a
);
  logic pclk, sclk;
  logic p_tgl, good_tgl, loss_tgl, on_sec;
  logic en_p, en_s;

  // Strapped role decode: 1 makes A primary (R1)
  assign pclk = pri_sel ? clk_a : clk_b;
  assign sclk = pri_sel ? clk_b : clk_a;

  cfo_qualifier #(.QUAL_CYCLES(QUAL_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_qual (
    .pclk(pclk), .rst(rst), .loss_tgl(loss_tgl),
    .p_tgl(p_tgl), .good_tgl(good_tgl)
  );

  cfo_loss_det #(.LOSS_CYCLES(LOSS_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_loss (
    .sclk(sclk), .rst(rst), .p_tgl(p_tgl), .good_tgl(good_tgl),
    .loss_tgl(loss_tgl), .on_sec(on_sec)
  );

  cfo_glitchless_mux #(.SYNC_STAGES(SYNC_STAGES)) u_mux (
    .pclk(pclk), .sclk(sclk), .rst(rst), .use_sec(on_sec),
    .clk_out(clk_out), .en_p(en_p), .en_s(en_s)
  );

  assign active_is_a = pri_sel ? en_p : en_s;

  p_status_r2: assert property (@(posedge sclk) disable iff (rst)
    active_is_a |-> (pri_sel ? !en_s : !en_p));
endmodule

// File: tb/tb_clk_failover.sv
`timescale 1ns/100ps
module tb_clk_failover;
  localparam int HA = 37;   // half period of input A
  localparam int HB = 39;   // half period of input B
  localparam int MIN_PHASE = 37;

  typedef struct {
    string tag;
    int    src;   // 0: A, 1: B, 2: held low
    bit    st;
  } exp_t;

  logic tclk = 1'b0;
  logic clk_a = 1'b0, clk_b = 1'b0;
  logic run_a = 1'b1, run_b = 1'b1;
  logic rst = 1'b1, pri_sel = 1'b1;
  logic clk_out, active_is_a;

  int checks = 0, errors = 0;
  int glitches = 0;
  bit mon_en = 1'b0, have_edge = 1'b0;
  realtime last_edge = 0.0;
  exp_t q[$];

  clk_failover dut (
    .clk_a(clk_a), .clk_b(clk_b), .rst(rst), .pri_sel(pri_sel),
    .clk_out(clk_out), .active_is_a(active_is_a)
  );

  always #5 tclk = ~tclk;
  initial forever begin #HA; if (run_a) clk_a = ~clk_a; end
  initial forever begin #HB; if (run_b) clk_b = ~clk_b; end

  // Phase width monitor (R4)
  always @(clk_out) begin
    if (mon_en) begin
      if (have_edge && ($realtime - last_edge) < MIN_PHASE) glitches++;
      have_edge = 1'b1;
      last_edge = $realtime;
    end
  end

  // Scoreboard monitor
  initial forever begin
    exp_t it;
    logic exp_clk;
    wait (q.size() > 0);
    @(posedge tclk);
    #0.5;
    it = q[0];
    exp_clk = (it.src == 0) ? clk_a : (it.src == 1) ? clk_b : 1'b0;
    checks++;
    if (clk_out !== exp_clk || active_is_a !== it.st) begin
      errors++;
      $display("FAIL %s: clk_out=%b active_is_a=%b expected clk_out=%b active_is_a=%b",
               it.tag, clk_out, active_is_a, exp_clk, it.st);
    end
    void'(q.pop_front());
  end

  task automatic expect_st(input string tag, input int src, input bit st);
    for (int i = 0; i < 3; i++) begin
      exp_t it;
      it.tag = tag; it.src = src; it.st = st;
      q.push_back(it);
      wait (q.size() == 0);
      #17;
    end
  endtask

  task automatic do_reset(input bit sel);
    mon_en = 1'b0;
    #1;
    rst = 1'b1;
    pri_sel = sel;
    #200;
    expect_st("R7 reset holds output low", 2, 1'b0);
    #0.3;
    rst = 1'b0;
    have_edge = 1'b0;
    mon_en = 1'b1;
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge tclk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // A primary
    do_reset(1'b1);
    #(40*2*HA);
    expect_st("R1 A primary after reset", 0, 1'b1);
    expect_st("R2 status shows A", 0, 1'b1);

    run_a = 1'b0;
    #(30*2*HB);
    expect_st("R3 switch to B on loss of A", 1, 1'b0);

    run_a = 1'b1;
    #(1000*2*HA);
    expect_st("R5 holdoff keeps B", 1, 1'b0);
    #(70*2*HA);
    expect_st("R5 A retaken after qualification", 0, 1'b1);

    // Dropout during qualification
    run_a = 1'b0;
    #(30*2*HB);
    expect_st("R3 second loss of A", 1, 1'b0);
    run_a = 1'b1;
    #(500*2*HA);
    run_a = 1'b0;
    #(30*2*HB);
    expect_st("R6 dropout mid-qualification stays on B", 1, 1'b0);
    run_a = 1'b1;
    #(1000*2*HA);
    expect_st("R6 count restarted, still B", 1, 1'b0);
    #(70*2*HA);
    expect_st("R6 A retaken after full recount", 0, 1'b1);

    // B primary
    do_reset(1'b0);
    #(40*2*HB);
    expect_st("R1 B primary after reset", 1, 1'b0);
    run_b = 1'b0;
    #(30*2*HA);
    expect_st("R3 switch to A on loss of B", 0, 1'b1);
    run_b = 1'b1;
    #(1000*2*HB);
    expect_st("R5 holdoff keeps A", 0, 1'b1);
    #(70*2*HB);
    expect_st("R5 B retaken after qualification", 1, 1'b0);

    checks++;
    if (glitches != 0) begin
      errors++;
      $display("FAIL R4 short phases on clk_out: %0d, expected 0", glitches);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule